// File: doc/BRIEF.md
# Frame Early-Termination Controller

This block sits beside the node arrays of an iterative min-sum decoder that processes two frames at once, interleaved: while one frame occupies the check units, the other occupies the variable units, and the two swap after a fixed number of clock cycles per phase. Every check unit already produces a one-bit parity flag from the sign XOR of its incoming variable-to-check messages. The controller reduces all of these flags with a single wide OR. When that reduction is zero at the end of a check phase, the frame in the check units has converged.

Each of the two interleaved slots keeps its own converged flag and its own iteration count. A slot that has converged, or that has spent its whole iteration budget, drops its unit enables for the rest of its frame time. The frame schedule is not changed, so frame start times and throughput stay the same. The clock is never gated. On the cycle after a slot terminates, the controller raises a one-cycle request for the final hard decision, tagged with the slot and with whether the stop was early.

The decoder's sequencer drives the position within the phase and the slot currently in the check units. A new-frame strobe, naming a slot, restarts that slot.

Top module: `etc_ctrl`

## Requirements
- R1: While reset (active-low, synchronous) is applied, and after it until a frame is started, both slots are idle: `chk_en` and `var_en` are 0 and `hd_req` is 0.
- R2: A `frame_start` pulse clears the iteration count and converged flag of slot `frame_slot` (0 even, 1 odd). From the next cycle that slot is active: its enable is 1 whenever it occupies the unit array.
- R3: `chk_en` equals the active state of slot `chk_slot`, and `var_en` equals the active state of the other slot, in the same cycle.
- R4: At the clock edge that ends a check phase (`cyc_idx` equal to PHASE_CYC-1), an active slot in the check units completes one iteration. If the OR of all bits of `chk_par` (bit 1 means that constraint is unsatisfied) is 0, that slot becomes converged, and its enable is 0 from the next cycle.
- R5: `chk_par` is ignored on every cycle that does not end a check phase, and at the edge ending a phase it affects only the slot named by `chk_slot`.
- R6: A converged slot stays inactive regardless of `chk_par` until the next `frame_start` for that slot.
- R7: A slot that completes MAX_ITER iterations without converging becomes inactive.
- R8: In the cycle after a slot stops (by convergence or by budget), `hd_req` is 1 for exactly one cycle, with `hd_slot` naming that slot and `hd_conv` 1 for convergence and 0 for budget exhaustion. Otherwise `hd_req` is 0.
- R9: If `frame_start` for a slot coincides with the edge ending that slot's check phase, the restart wins: no iteration is counted and the parity is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, free-running |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | New-frame strobe for slot `frame_slot` |
| frame_slot | input | 1 | Slot being restarted (0 even, 1 odd) |
| chk_par | input | NUM_CHK | Per-check parity flags, 1 = unsatisfied |
| cyc_idx | input | PH_W | Cycle position within the current phase |
| chk_slot | input | 1 | Slot now occupying the check units |
| chk_en | output | 1 | Enable for all check units |
| var_en | output | 1 | Enable for all variable units |
| hd_req | output | 1 | One-cycle request for the final hard decision |
| hd_slot | output | 1 | Slot the request belongs to |
| hd_conv | output | 1 | 1 if the stop was due to convergence |

## Verification
The bench builds the controller with six check flags, a budget of four iterations and four-cycle phases. Six flags are few enough that all 64 parity patterns can be presented at a phase-ending edge, and they are not a power of two, so the padded leaves of the OR tree are exercised. The short budget lets a sweep cover every pair of convergence iterations for the even and odd slots, including "never", so budget exhaustion, convergence on the final iteration and the interaction of the two slots all occur.

// File: rtl/etc_pkg.sv
// Shared definitions for the early-termination controller.
// Assumes exactly two interleaved frame slots.
package etc_pkg;
    localparam int NUM_SLOTS = 2;

    typedef enum logic {
        SLOT_EVEN = 1'b0,
        SLOT_ODD  = 1'b1
    } slot_e;
endpackage

// File: rtl/etc_or_tree.sv
// Wide OR reduction built as a balanced binary tree in heap order.
// Unused leaves (when WIDTH is not a power of two) are tied to zero.
// Assumes WIDTH >= 1; purely combinational.
module etc_or_tree #(
    parameter int WIDTH = 176
) (
    input  logic [WIDTH-1:0] din,
    output logic             any
);
    localparam int LVLS   = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int LEAVES = 1 << LVLS;

    logic [2*LEAVES-1:1] node;

    // leaves: real inputs, then zero padding
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < WIDTH) begin : g_real
            assign node[LEAVES+j] = din[j];
        end else begin : g_pad
            assign node[LEAVES+j] = 1'b0;
        end
    end

    // internal nodes: each is the OR of its two children
    for (genvar i = 1; i < LEAVES; i++) begin : g_node
        assign node[i] = node[2*i] | node[2*i+1];
    end

    assign any = node[1];
endmodule

// File: rtl/etc_slot_ctl.sv
// Termination state of one interleaved frame slot: iteration count and
// converged flag. The slot is active while not converged and the budget
// is not spent. Reset leaves the slot idle (budget spent, not converged).
// Assumes 'sample' is high only on the edge ending this slot's check phase.
module etc_slot_ctl #(
    parameter int MAX_ITER = 15,
    parameter int IT_W     = $clog2(MAX_ITER + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic par_any,
    output logic active,
    output logic term,
    output logic term_conv
);
    localparam logic [IT_W-1:0] BUDGET = IT_W'(MAX_ITER);

    logic [IT_W-1:0] iter_q;
    logic            conv_q;
    logic [IT_W-1:0] iter_nx;
    logic            step;

    assign active    = !conv_q && (iter_q != BUDGET);
    assign step      = sample && active && !clear;
    assign iter_nx   = iter_q + 1'b1;
    assign term      = step && (!par_any || (iter_nx == BUDGET));
    assign term_conv = step && !par_any;

    // iteration count and converged flag; restart has priority over a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_q <= BUDGET;
            conv_q <= 1'b0;
        end else if (clear) begin
            iter_q <= '0;
            conv_q <= 1'b0;
        end else if (step) begin
            iter_q <= iter_nx;
            if (!par_any) begin
                conv_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/etc_ctrl.sv
// Early-termination controller for a two-frame interleaved decoder.
// ORs all check parity flags, samples the result at the end of each check
// phase for the slot in the check units, holds per-slot termination state,
// and drives the check/variable unit enables and a hard-decision request.
// Assumes the sequencer supplies cyc_idx and chk_slot; PHASE_CYC >= 2.
module etc_ctrl
    import etc_pkg::*;
#(
    parameter int NUM_CHK   = 176,
    parameter int MAX_ITER  = 15,
    parameter int PHASE_CYC = 4,
    parameter int PH_W      = $clog2(PHASE_CYC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               frame_slot,
    input  logic [NUM_CHK-1:0] chk_par,
    input  logic [PH_W-1:0]    cyc_idx,
    input  logic               chk_slot,
    output logic               chk_en,
    output logic               var_en,
    output logic               hd_req,
    output logic               hd_slot,
    output logic               hd_conv
);
    localparam int IT_W = $clog2(MAX_ITER + 1);
    localparam logic [PH_W-1:0] LAST_CYC = PH_W'(PHASE_CYC - 1);

    logic                 par_any;
    logic                 phase_end;
    logic [NUM_SLOTS-1:0] active;
    logic [NUM_SLOTS-1:0] term;
    logic [NUM_SLOTS-1:0] term_conv;

    etc_or_tree #(.WIDTH(NUM_CHK)) u_or (
        .din (chk_par),
        .any (par_any)
    );

    assign phase_end = (cyc_idx == LAST_CYC);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        etc_slot_ctl #(.MAX_ITER(MAX_ITER), .IT_W(IT_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (frame_start && (frame_slot == 1'(s))),
            .sample    (phase_end && (chk_slot == 1'(s))),
            .par_any   (par_any),
            .active    (active[s]),
            .term      (term[s]),
            .term_conv (term_conv[s])
        );
    end

    assign chk_en = active[chk_slot];
    assign var_en = active[~chk_slot];

    // hard-decision request, one cycle after a slot stops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_req  <= 1'b0;
            hd_slot <= SLOT_EVEN;
            hd_conv <= 1'b0;
        end else begin
            hd_req  <= |term;
            hd_slot <= term[SLOT_ODD];
            hd_conv <= |term_conv;
        end
    end
endmodule

// File: rtl/etc_checker.sv
// Property checker for etc_ctrl, bound to every instance.
// Tracks per-slot iteration counts from the ports to bound the budget.
module etc_checker #(
    parameter int NUM_CHK   = 176,
    parameter int MAX_ITER  = 15,
    parameter int PHASE_CYC = 4,
    parameter int PH_W      = $clog2(PHASE_CYC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               frame_slot,
    input logic [NUM_CHK-1:0] chk_par,
    input logic [PH_W-1:0]    cyc_idx,
    input logic               chk_slot,
    input logic               chk_en,
    input logic               var_en,
    input logic               hd_req,
    input logic               hd_slot,
    input logic               hd_conv
);
    localparam int CW = $clog2(MAX_ITER + 2);
    localparam logic [PH_W-1:0] LAST_CYC = PH_W'(PHASE_CYC - 1);

    logic [CW-1:0] seen [2];

    // count iterations each slot performs while enabled in the check units
    always_ff @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (!rst_n) begin
                seen[s] <= '0;
            end else if (frame_start && frame_slot == 1'(s)) begin
                seen[s] <= '0;
            end else if (chk_en && chk_slot == 1'(s) && cyc_idx == LAST_CYC
                         && seen[s] <= CW'(MAX_ITER)) begin
                seen[s] <= seen[s] + 1'b1;
            end
        end
    end

    // R1: idle outputs while reset is held
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!hd_req && !chk_en && !var_en));

    // R2: a restarted slot is enabled on the next cycle
    p_start_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> ((chk_slot == $past(frame_slot)) ? chk_en : var_en));

    // R4: all parities satisfied at phase end stops the slot
    p_conv_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && cyc_idx == LAST_CYC && chk_par == '0
         && !(frame_start && frame_slot == chk_slot))
        |=> (hd_req && hd_conv));

    // R5: terminations only follow a phase-ending edge
    p_phase_end_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hd_req |-> ($past(cyc_idx) == LAST_CYC));

    // R7: no slot runs more than the budget
    p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen[0] <= CW'(MAX_ITER)) && (seen[1] <= CW'(MAX_ITER)));

    // R8: request is a single-cycle pulse naming the slot that was sampled
    p_hd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hd_req |=> !hd_req);

    p_hd_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hd_req |-> (hd_slot == $past(chk_slot)));
endmodule

bind etc_ctrl etc_checker #(
    .NUM_CHK   (NUM_CHK),
    .MAX_ITER  (MAX_ITER),
    .PHASE_CYC (PHASE_CYC),
    .PH_W      (PH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_slot  (frame_slot),
    .chk_par     (chk_par),
    .cyc_idx     (cyc_idx),
    .chk_slot    (chk_slot),
    .chk_en      (chk_en),
    .var_en      (var_en),
    .hd_req      (hd_req),
    .hd_slot     (hd_slot),
    .hd_conv     (hd_conv)
);

// File: tb/sim_etc_ctrl.sv
// Self-checking bench: small configuration, sweeps of convergence points
// and all parity patterns, checked against a model built from the brief.
module sim_etc_ctrl;
    localparam int N  = 6;
    localparam int MI = 4;
    localparam int PH = 4;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          frame_slot = 1'b0;
    logic [N-1:0]  chk_par = '0;
    logic [PW-1:0] cyc_idx = '0;
    logic          chk_slot = 1'b0;
    logic          chk_en, var_en, hd_req, hd_slot, hd_conv;

    int  checks = 0;
    int  errors = 0;
    bit  fin = 1'b0;
    int  m_iter [2];
    bit  m_conv [2];
    int  hd_seen;
    string ctx = "R3";

    always #4 clk = ~clk;

    etc_ctrl #(.NUM_CHK(N), .MAX_ITER(MI), .PHASE_CYC(PH), .PH_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .frame_slot(frame_slot), .chk_par(chk_par), .cyc_idx(cyc_idx),
        .chk_slot(chk_slot), .chk_en(chk_en), .var_en(var_en),
        .hd_req(hd_req), .hd_slot(hd_slot), .hd_conv(hd_conv)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual %0d expected %0d at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    function automatic bit m_act(input int t);
        return !m_conv[t] && (m_iter[t] != MI);
    endfunction

    // one clock cycle: drive, check enables, clock, check request, advance schedule
    task automatic tick(input bit fs, input bit fsl, input logic [N-1:0] par);
        int  s;
        bit  samp;
        bit  eh, es, ec;
        int  ni [2];
        bit  nc [2];
        frame_start = fs;
        frame_slot  = fsl;
        chk_par     = par;
        #1;
        s = int'(chk_slot);
        chk(chk_en === m_act(s), "R3 chk_en", int'(chk_en), int'(m_act(s)));
        chk(var_en === m_act(1 - s), "R3 var_en", int'(var_en), int'(m_act(1 - s)));
        samp = (cyc_idx == PW'(PH - 1));
        eh = 0; es = 0; ec = 0;
        for (int t = 0; t < 2; t++) begin
            ni[t] = m_iter[t];
            nc[t] = m_conv[t];
            if (fs && int'(fsl) == t) begin
                ni[t] = 0;
                nc[t] = 0;
            end else if (samp && t == s && m_act(t)) begin
                ni[t] = m_iter[t] + 1;
                nc[t] = (par == '0);
                if (nc[t] || ni[t] == MI) begin
                    eh = 1; es = bit'(t); ec = nc[t];
                end
            end
        end
        @(posedge clk);
        #2;
        for (int t = 0; t < 2; t++) begin
            m_iter[t] = ni[t];
            m_conv[t] = nc[t];
        end
        chk(hd_req === eh, "R4/R8 hd_req", int'(hd_req), int'(eh));
        if (eh) begin
            hd_seen++;
            chk(hd_slot === es, "R8 hd_slot", int'(hd_slot), int'(es));
            chk(hd_conv === ec, "R8 hd_conv", int'(hd_conv), int'(ec));
        end
        frame_start = 1'b0;
        if (cyc_idx == PW'(PH - 1)) begin
            cyc_idx  = '0;
            chk_slot = ~chk_slot;
        end else begin
            cyc_idx = cyc_idx + 1'b1;
        end
    endtask

    // idle cycles until the edge that ends slot s's check phase, then apply par there
    task automatic to_sample(input bit s, input logic [N-1:0] par);
        while (!(chk_slot == s && cyc_idx == PW'(PH - 1))) tick(0, 0, '1);
        tick(0, 0, par);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_iter[0] = MI; m_iter[1] = MI;
        m_conv[0] = 0;  m_conv[1] = 0;
        hd_seen = 0;

        // R1: reset state, both slot positions
        repeat (3) begin
            @(posedge clk); #2;
            chk(hd_req === 1'b0, "R1 hd_req", int'(hd_req), 0);
            chk(chk_en === 1'b0 && var_en === 1'b0, "R1 enables", int'(chk_en), 0);
            chk_slot = ~chk_slot;
        end
        chk_slot = 1'b0;
        rst_n = 1'b1;
        ctx = "R1";
        for (int c = 0; c < 2 * PH; c++) tick(0, 0, '0);

        // R2 R4 R6 R7 R8: sweep convergence iteration of both slots (MI+1 = never)
        for (int k0 = 1; k0 <= MI + 1; k0++) begin
            for (int k1 = 1; k1 <= MI + 1; k1++) begin
                ctx = "R2";
                tick(1, 0, '0);
                tick(1, 1, '0);
                ctx = "R4";
                for (int c = 0; c < 2 * PH * (MI + 1); c++) begin
                    int s;
                    int k;
                    logic [N-1:0] p;
                    s = int'(chk_slot);
                    k = (s == 0) ? k0 : k1;
                    if (cyc_idx != PW'(PH - 1)) begin
                        p = '0;                                  // R5: ignored mid-phase
                    end else if (!m_act(s)) begin
                        p = '1;                                  // R6: stays converged
                    end else if (m_iter[s] + 1 >= k) begin
                        p = '0;
                    end else begin
                        p = N'(1) << ((m_iter[s] * 3 + k0 + k1) % N);
                    end
                    tick(0, 0, p);
                end
                ctx = "R7";
                chk(!m_act(0) && !m_act(1), "R7 both slots stopped",
                    int'(chk_en | var_en), 0);
                chk(chk_en === 1'b0 && var_en === 1'b0, "R6/R7 enables low",
                    int'(chk_en | var_en), 0);
            end
        end

        // R4 R5: every parity pattern at the sampling edge of slot 0
        ctx = "R5";
        for (int p = 0; p < (1 << N); p++) begin
            tick(1, 0, '0);
            to_sample(0, N'(p));
            #1;
            chk((chk_slot == 1'b1) && (var_en === (p != 0)), "R4 conv by pattern",
                int'(var_en), int'(p != 0));
        end

        // R9: restart coinciding with the sampling edge wins
        ctx = "R9";
        tick(1, 0, '0);
        to_sample(0, '1);
        while (!(chk_slot == 1'b0 && cyc_idx == PW'(PH - 1))) tick(0, 0, '1);
        hd_seen = 0;
        tick(1, 0, '0);
        chk(hd_seen == 0, "R9 no termination", hd_seen, 0);
        chk(m_iter[0] == 0, "R9 count cleared", m_iter[0], 0);
        #1;
        chk(var_en === 1'b1, "R9 slot still active", int'(var_en), 1);
        for (int c = 0; c < 2 * PH * (MI + 1); c++) tick(0, 0, '1);
        chk(!m_act(0), "R7 budget after restart", int'(m_act(0)), 0);

        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule